// File: doc/BRIEF.md
# Register-File MAC Datapath

This block is the arithmetic heart of a small core: an eight-entry register file of four-bit words feeding one multiply-accumulate unit. Each issued operation names three source registers (two factors and an accumulator) and one destination. The two factors are multiplied, the accumulator value is added, and the low four bits of the sum are written to the destination on the next clock edge. A flag records whether any upper bit of the sum was discarded.

Every read port is built from plain gates. A decoder turns the three-bit address into an eight-bit one-hot mask, and each bit of the result is the OR of eight AND terms. The multiplier is an array of sixteen AND partial products reduced by rows of full adders, and the accumulate adder is a ripple of full adders. A load path writes an input word directly into a register. Without it, a register file that resets to zero could never hold anything other than zero.

Top module: `rfmac_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers and `ovf` to 0.
- R2: The three read ports are combinational and independent. `opa_data`, `opb_data` and `acc_data` return the register addressed by `rd_a_addr`, `rd_b_addr` and `rd_c_addr` in the same cycle.
- R3: `result` equals (opa*opb + acc) mod 16 combinationally. When `op_valid` is high and `ld_valid` is low at a rising edge, this value is written to register `wr_addr`.
- R4: On a MAC write, `ovf` is set to 1 if opa*opb + acc >= 16 and cleared to 0 otherwise. `ovf` keeps its value in cycles with no MAC write, including load cycles.
- R5: With `op_valid` and `ld_valid` both low, no register and not `ovf` changes, whatever the address inputs are.
- R6: A read of the destination register in the cycle of its write returns the old value. The new value appears after the edge.
- R7: A MAC whose three source addresses and destination are all the same register stores (x*x + x) mod 16 computed from that register's old value x.
- R8: A write changes only the destination register. The other seven keep their values.
- R9: When `ld_valid` is high at a rising edge, `ld_data` is written to register `wr_addr`. A load takes priority over a MAC issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Issue a MAC write this cycle |
| ld_valid | input | 1 | Load `ld_data` into `wr_addr` this cycle |
| ld_data | input | 4 | Load value |
| rd_a_addr | input | 3 | First factor register address |
| rd_b_addr | input | 3 | Second factor register address |
| rd_c_addr | input | 3 | Accumulator register address |
| wr_addr | input | 3 | Destination register address |
| opa_data | output | 4 | First factor read data |
| opb_data | output | 4 | Second factor read data |
| acc_data | output | 4 | Accumulator read data |
| result | output | 4 | Truncated MAC sum |
| ovf | output | 1 | Discarded-bits flag of the last MAC write |

## Verification
A corrupted register shows up at any read port that addresses it, in the same cycle, because reads are combinational. A write to the wrong entry shows up one edge later when all eight entries are swept through the three ports. A fault in one selector's mask is caught by reading each entry through all three ports with different rotations. A fault in the multiplier or adder appears at `result` before the edge and in the destination register after it. A wrong overflow decision appears on `ovf` one edge after the MAC, and a flag that fails to hold appears after a following load or idle cycle.

// File: rtl/rfmac_pkg.sv
`timescale 1ns/1ps
package rfmac_pkg;
   localparam int unsigned RF_DATA_W_DEF = 4;
   localparam int unsigned RF_DEPTH_DEF  = 8;

   typedef enum logic [1:0] {
      WSRC_NONE = 2'd0,
      WSRC_MAC  = 2'd1,
      WSRC_LOAD = 2'd2
   } wsrc_e;
endpackage

// File: rtl/rfmac_onehot_dec.sv
`timescale 1ns/1ps
module rfmac_onehot_dec #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DEPTH-1:0]  mask
);
   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
      $error("rfmac_onehot_dec: ADDR_W too narrow for DEPTH");
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_line
      assign mask[k] = (addr == ADDR_W'(k));
   end
endmodule

// File: rtl/rfmac_andor_sel.sv
`timescale 1ns/1ps
module rfmac_andor_sel #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned DATA_W = 4
) (
   input  logic [DEPTH*DATA_W-1:0] words,
   input  logic [DEPTH-1:0]        mask,
   output logic [DATA_W-1:0]       dout
);
   logic [DATA_W-1:0] gated [DEPTH];

   // AND stage: one mask line per word
   for (genvar k = 0; k < DEPTH; k++) begin : g_and
      assign gated[k] = words[k*DATA_W +: DATA_W] & {DATA_W{mask[k]}};
   end

   // OR merge of the masked words
   always_comb begin
      dout = '0;
      for (int k = 0; k < DEPTH; k++) begin
         dout = dout | gated[k];
      end
   end
endmodule

// File: rtl/rfmac_fa.sv
`timescale 1ns/1ps
module rfmac_fa (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic hx;
   assign hx = x ^ y;
   assign s  = hx ^ ci;
   assign co = (x & y) | (ci & hx);
endmodule

// File: rtl/rfmac_mac.sv
`timescale 1ns/1ps
module rfmac_mac #(
   parameter int unsigned DATA_W = 4,
   localparam int unsigned SUM_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] fa_in,
   input  logic [DATA_W-1:0] fb_in,
   input  logic [DATA_W-1:0] acc_in,
   output logic [SUM_W-1:0]  sum
);
   if (DATA_W < 2) begin : g_bad_w
      $error("rfmac_mac: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] pp [DATA_W];
   logic [DATA_W-1:0] rs [DATA_W];
   logic              rc [DATA_W];
   logic [SUM_W-1:0]  prod;

   // partial products: one AND per factor bit pair
   for (genvar i = 0; i < DATA_W; i++) begin : g_pp_row
      for (genvar j = 0; j < DATA_W; j++) begin : g_pp_bit
         assign pp[i][j] = fa_in[j] & fb_in[i];
      end
   end

   assign rs[0] = pp[0];
   assign rc[0] = 1'b0;

   // each row adds the next partial product to the shifted running sum
   for (genvar i = 1; i < DATA_W; i++) begin : g_row
      logic [DATA_W-1:0] shx;
      logic [DATA_W:0]   cy;
      assign shx   = {rc[i-1], rs[i-1][DATA_W-1:1]};
      assign cy[0] = 1'b0;
      for (genvar j = 0; j < DATA_W; j++) begin : g_cell
         rfmac_fa u_fa (
            .x (shx[j]),
            .y (pp[i][j]),
            .ci(cy[j]),
            .s (rs[i][j]),
            .co(cy[j+1])
         );
      end
      assign rc[i]     = cy[DATA_W];
      assign prod[i-1] = rs[i-1][0];
   end

   assign prod[SUM_W-1:DATA_W-1] = {rc[DATA_W-1], rs[DATA_W-1]};

   // accumulate: max product plus max acc stays below 2**SUM_W, top carry is never needed
   logic [SUM_W-1:0] ext;
   logic [SUM_W-1:0] acy;
   assign ext    = {{DATA_W{1'b0}}, acc_in};
   assign acy[0] = 1'b0;

   for (genvar i = 0; i < SUM_W; i++) begin : g_acc
      if (i < SUM_W - 1) begin : g_full
         rfmac_fa u_fa (
            .x (prod[i]),
            .y (ext[i]),
            .ci(acy[i]),
            .s (sum[i]),
            .co(acy[i+1])
         );
      end else begin : g_top
         assign sum[i] = prod[i] ^ ext[i] ^ acy[i];
      end
   end
endmodule

// File: rtl/rfmac_core.sv
`timescale 1ns/1ps
module rfmac_core
   import rfmac_pkg::*;
#(
   parameter int unsigned DATA_W = RF_DATA_W_DEF,
   parameter int unsigned DEPTH  = RF_DEPTH_DEF,
   localparam int unsigned ADDR_W = $clog2(DEPTH),
   localparam int unsigned SUM_W  = 2 * DATA_W,
   localparam int unsigned NPORT  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic              ld_valid,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] rd_a_addr,
   input  logic [ADDR_W-1:0] rd_b_addr,
   input  logic [ADDR_W-1:0] rd_c_addr,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] opa_data,
   output logic [DATA_W-1:0] opb_data,
   output logic [DATA_W-1:0] acc_data,
   output logic [DATA_W-1:0] result,
   output logic              ovf
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("rfmac_core: DEPTH must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("rfmac_core: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0]       mem [DEPTH];
   logic [DEPTH*DATA_W-1:0] mem_flat;
   logic [ADDR_W-1:0]       rd_addr [NPORT];
   logic [DEPTH-1:0]        rd_mask [NPORT];
   logic [DATA_W-1:0]       rd_data [NPORT];
   logic [DEPTH-1:0]        wr_mask;
   logic [SUM_W-1:0]        mac_sum;
   logic [DATA_W-1:0]       wdata;
   logic                    ovf_next;
   wsrc_e                   wsrc;

   for (genvar k = 0; k < DEPTH; k++) begin : g_flat
      assign mem_flat[k*DATA_W +: DATA_W] = mem[k];
   end

   assign rd_addr[0] = rd_a_addr;
   assign rd_addr[1] = rd_b_addr;
   assign rd_addr[2] = rd_c_addr;

   // three independent decode plus AND-OR read ports
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      rfmac_onehot_dec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dec (
         .addr(rd_addr[p]),
         .mask(rd_mask[p])
      );
      rfmac_andor_sel #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sel (
         .words(mem_flat),
         .mask (rd_mask[p]),
         .dout (rd_data[p])
      );
   end

   assign opa_data = rd_data[0];
   assign opb_data = rd_data[1];
   assign acc_data = rd_data[2];

   rfmac_mac #(.DATA_W(DATA_W)) u_mac (
      .fa_in (rd_data[0]),
      .fb_in (rd_data[1]),
      .acc_in(rd_data[2]),
      .sum   (mac_sum)
   );

   assign result   = mac_sum[DATA_W-1:0];
   assign ovf_next = |mac_sum[SUM_W-1:DATA_W];

   rfmac_onehot_dec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wdec (
      .addr(wr_addr),
      .mask(wr_mask)
   );

   always_comb begin
      if (ld_valid)      wsrc = WSRC_LOAD;
      else if (op_valid) wsrc = WSRC_MAC;
      else               wsrc = WSRC_NONE;
   end

   assign wdata = (wsrc == WSRC_LOAD) ? ld_data : result;

   for (genvar k = 0; k < DEPTH; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            mem[k] <= '0;
         end else if (wsrc != WSRC_NONE && wr_mask[k]) begin
            mem[k] <= wdata;
         end
      end

      // R8
      other_stable_chk: assert property (@(posedge clk) disable iff (rst)
         !((op_valid || ld_valid) && wr_addr == ADDR_W'(k)) |=> $stable(mem[k]));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ovf <= 1'b0;
      end else if (wsrc == WSRC_MAC) begin
         ovf <= ovf_next;
      end
   end

   // R2
   rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rd_mask[0]) && $onehot0(rd_mask[1]) && $onehot0(rd_mask[2]));

   // R2
   rd_match_chk: assert property (@(posedge clk) disable iff (rst)
      opa_data == mem[rd_a_addr] && opb_data == mem[rd_b_addr] && acc_data == mem[rd_c_addr]);

   // R3
   mac_write_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !ld_valid) |=> mem[$past(wr_addr)] ==
         DATA_W'($past(opa_data) * $past(opb_data) + $past(acc_data)));

   // R4
   ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(op_valid && !ld_valid) |=> $stable(ovf));

   // R9
   load_write_chk: assert property (@(posedge clk) disable iff (rst)
      ld_valid |=> mem[$past(wr_addr)] == $past(ld_data));

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (mem_flat == '0 && !ovf));
endmodule

// File: tb/rfmac_core_tb.sv
`timescale 1ns/1ps
module rfmac_core_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_valid = 1'b0;
   logic       ld_valid = 1'b0;
   logic [3:0] ld_data = '0;
   logic [2:0] rd_a_addr = '0;
   logic [2:0] rd_b_addr = '0;
   logic [2:0] rd_c_addr = '0;
   logic [2:0] wr_addr = '0;
   logic [3:0] opa_data, opb_data, acc_data, result;
   logic       ovf;

   int nchk = 0;
   int nerr = 0;
   int model [8];
   int movf = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rfmac_core u_dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .ld_valid(ld_valid),
      .ld_data(ld_data), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
      .rd_c_addr(rd_c_addr), .wr_addr(wr_addr), .opa_data(opa_data),
      .opb_data(opb_data), .acc_data(acc_data), .result(result), .ovf(ovf)
   );

   task automatic chk(string tag, int got, int exp);
      nchk++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic sweep(string tag);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         rd_a_addr = 3'(k);
         rd_b_addr = 3'((k + 3) % 8);
         rd_c_addr = 3'((k + 5) % 8);
         #1;
         chk({tag, " porta"}, opa_data, model[k]);
         chk({tag, " portb"}, opb_data, model[(k + 3) % 8]);
         chk({tag, " portc"}, acc_data, model[(k + 5) % 8]);
      end
      chk({tag, " ovf"}, ovf, movf);
   endtask

   task automatic do_load(int d, int v);
      @(negedge clk);
      ld_valid = 1'b1; wr_addr = 3'(d); ld_data = 4'(v);
      @(negedge clk);
      ld_valid = 1'b0;
      model[d] = v;
   endtask

   task automatic do_mac(int a, int b, int c, int d, string tag);
      int full;
      @(negedge clk);
      rd_a_addr = 3'(a); rd_b_addr = 3'(b); rd_c_addr = 3'(c); wr_addr = 3'(d);
      op_valid = 1'b1;
      full = model[a] * model[b] + model[c];
      #1;
      chk({tag, " R3 result"}, result, full % 16);
      @(negedge clk);
      op_valid = 1'b0;
      model[d] = full % 16;
      movf = (full >= 16) ? 1 : 0;
      rd_a_addr = 3'(d);
      #1;
      chk({tag, " R3 dest"}, opa_data, model[d]);
      chk({tag, " R4 ovf"}, ovf, movf);
   endtask

   task automatic t_reset_state();
      sweep("R1 initial");
   endtask

   task automatic t_loads();
      for (int k = 0; k < 8; k++) do_load(k, (k * 5 + 3) % 16);
      sweep("R9 load");
   endtask

   task automatic t_random_macs();
      for (int n = 0; n < 40; n++) begin
         do_mac($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                $urandom_range(0, 7), "rand");
      end
      sweep("R2 after random");
   endtask

   task automatic t_same_addr();
      int x;
      for (int k = 0; k < 8; k++) begin
         do_load(k, 15 - k * 2);
         x = model[k];
         do_mac(k, k, k, k, "R7 same");
         chk("R7 value", model[k], (x * x + x) % 16);
      end
   endtask

   task automatic t_old_read();
      int full;
      do_load(2, 7);
      do_load(5, 3);
      @(negedge clk);
      rd_a_addr = 3'd2; rd_b_addr = 3'd5; rd_c_addr = 3'd2; wr_addr = 3'd2;
      op_valid = 1'b1;
      full = 7 * 3 + 7;
      #1;
      chk("R6 old porta", opa_data, 7);
      chk("R6 old portc", acc_data, 7);
      @(negedge clk);
      op_valid = 1'b0;
      model[2] = full % 16;
      movf = 1;
      #1;
      chk("R6 new porta", opa_data, full % 16);
      chk("R4 ovf set", ovf, 1);
   endtask

   task automatic t_idle();
      @(negedge clk);
      op_valid = 1'b0; ld_valid = 1'b0;
      for (int n = 0; n < 6; n++) begin
         wr_addr = 3'(n); rd_a_addr = 3'(7 - n); rd_b_addr = 3'(n); rd_c_addr = 3'(n);
         @(negedge clk);
      end
      sweep("R5 idle");
   endtask

   task automatic t_ovf_rules();
      do_load(0, 1);
      do_load(1, 1);
      do_mac(0, 1, 0, 3, "R4 clear");
      chk("R4 cleared", ovf, 0);
      do_load(4, 15);
      do_mac(4, 4, 4, 6, "R4 max");
      chk("R4 max value", model[6], 0);
      chk("R4 max ovf", ovf, 1);
      do_load(7, 9);
      chk("R4 hold on load", ovf, 1);
      @(negedge clk); @(negedge clk);
      chk("R4 hold idle", ovf, 1);
   endtask

   task automatic t_load_priority();
      @(negedge clk);
      rd_a_addr = 3'd4; rd_b_addr = 3'd4; rd_c_addr = 3'd4; wr_addr = 3'd1;
      op_valid = 1'b1; ld_valid = 1'b1; ld_data = 4'd10;
      @(negedge clk);
      op_valid = 1'b0; ld_valid = 1'b0;
      model[1] = 10;
      sweep("R9 priority R8");
   endtask

   task automatic t_reset_again();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) model[k] = 0;
      movf = 0;
      sweep("R1 reset");
   endtask

   initial begin
      for (int k = 0; k < 8; k++) model[k] = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_loads();
      t_random_macs();
      t_same_addr();
      t_old_read();
      t_idle();
      t_ovf_rules();
      t_load_priority();
      t_reset_again();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule